// File: doc/BRIEF.md
# DDR2 Burst Latency Data Pipeline

This block is a cycle-level timing model of the data side of a DDR2 memory controller. It runs on the core clock. Each core clock it can accept a READ or WRITE command together with a burst-length choice. For a read, the command carries two 4n-bit internal words. After the programmed latency, the block drives those words out as n-bit beats. There are two beats per core clock: one on the rising half and one on the falling half. For a write, the block raises a request on the clocks in which the write data must be on the bus.

The delay is set by two inputs: a CAS latency and a posted additive latency. Read latency is their sum. Write latency is one clock less than read latency. A flag marks whether the current beats are write beats, which are centered on the strobe, or read beats, which are edge-aligned with it. Up to two commands may be outstanding. A later command is scheduled so that its beats never overlap or cut short the burst ahead of it. Latency inputs only take effect while the pipeline holds no command.

Top module: `ddr_burst_pipe`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pipeline empties. After that edge `cmd_rdy` is 1 and `rd_vld`, `wr_req` and `strb_ctr` are 0.
- R2: Take a READ accepted at edge E into an empty pipeline. `rd_vld` goes high after edge E+RL, where RL = AL + CL.
- R3: Take a WRITE accepted at edge E into an empty pipeline. `wr_req` goes high after edge E+RL-1.
- R4: A burst with `cmd_bl8`=0 (4 beats) lasts 2 consecutive clocks. A burst with `cmd_bl8`=1 (8 beats) lasts 4 consecutive clocks: the two internal words leave back to back.
- R5: Beat k of a read is `cmd_data[k*BEAT_W +: BEAT_W]`. Word 0 holds beats 0 to 3 and word 1 holds beats 4 to 7. In burst clock p, `rd_rise` carries beat 2p and `rd_fall` carries beat 2p+1.
- R6: `strb_ctr` is 1 in each write-beat clock, because write beats are center-aligned. It is 0 in each read-beat clock, because read beats are edge-aligned. `rd_vld` and `wr_req` are never high together.
- R7: CL below 3 counts as 3 and CL above 6 counts as 6. AL above 5 counts as 5.
- R8: A command accepted while another is still held starts at whichever is later: its own latency, or the clock after the previous burst ends. No beat is lost or overlapped.
- R9: At most two commands are held. While two are held, `cmd_rdy` is 0, and a command presented then starts no burst. `cmd_rdy` returns to 1 after the last beat clock of the head burst.
- R10: A command accepted while the pipeline is not empty uses the latency captured when the pipeline was last empty. A change to `cas_lat` or `add_lat` in that time has no effect until the pipeline empties.
- R11: `rd_rise` and `rd_fall` are 0 whenever `rd_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_vld | input | 1 | Command present this clock |
| cmd_wr | input | 1 | 1 = WRITE, 0 = READ |
| cmd_bl8 | input | 1 | 1 = 8-beat burst, 0 = 4-beat burst |
| cmd_data | input | 8*BEAT_W | Two internal read words (ignored for WRITE) |
| cas_lat | input | LAT_W | CAS latency setting |
| add_lat | input | LAT_W | Additive latency setting |
| cmd_rdy | output | 1 | A command can be accepted this clock |
| rd_vld | output | 1 | Read beats valid this clock |
| rd_rise | output | BEAT_W | Read beat of the first half-clock |
| rd_fall | output | BEAT_W | Read beat of the second half-clock |
| wr_req | output | 1 | Write data due this clock |
| strb_ctr | output | 1 | 1 = beats are center-aligned (write) |

## Verification
Every result is due a fixed number of registered clocks after the edge that accepts the command. Read beats arrive after edge E+AL+CL and write requests after edge E+AL+CL-1. A queued burst waits for the clock after the previous burst ends. `cmd_rdy` changes one edge after an accept or after the final beat. The bench records each output after every edge in a history indexed by edge number. It then checks the exact index where a burst should begin and end. It also checks the index one before the start and one after the end, so a burst that starts a clock early or late is caught.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

    typedef enum logic {
        BURST_RD = 1'b0,
        BURST_WR = 1'b1
    } burst_kind_t;

endpackage

// File: rtl/ddr_burst_lat.sv
module ddr_burst_lat #(
    parameter int LAT_W  = 3,
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 6,
    parameter int AL_MAX = 5,
    parameter int WAIT_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idle,
    input  logic [LAT_W-1:0]  cas_lat,
    input  logic [LAT_W-1:0]  add_lat,
    output logic [WAIT_W-1:0] rd_lat,
    output logic [WAIT_W-1:0] wr_lat
);

    typedef struct packed {
        logic [LAT_W-1:0] cl;
        logic [LAT_W-1:0] al;
    } hold_t;

    hold_t hold_d, hold_q;
    logic [LAT_W-1:0] cl_c, al_c;

    always_comb begin
        if (cas_lat < LAT_W'(CL_MIN))
            cl_c = LAT_W'(CL_MIN);
        else if (cas_lat > LAT_W'(CL_MAX))
            cl_c = LAT_W'(CL_MAX);
        else
            cl_c = cas_lat;

        al_c = (add_lat > LAT_W'(AL_MAX)) ? LAT_W'(AL_MAX) : add_lat;

        hold_d = hold_q;
        if (idle) begin
            hold_d.cl = cl_c;
            hold_d.al = al_c;
        end

        rd_lat = WAIT_W'(hold_d.cl) + WAIT_W'(hold_d.al);
        wr_lat = rd_lat - WAIT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q.cl <= LAT_W'(CL_MIN);
            hold_q.al <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/ddr_burst_ser.sv
module ddr_burst_ser #(
    parameter int BEAT_W = 8
) (
    input  logic [8*BEAT_W-1:0] data,
    input  logic [1:0]          ph,
    output logic [BEAT_W-1:0]   rise,
    output logic [BEAT_W-1:0]   fall
);

    localparam int PAIRS = 4;

    logic [BEAT_W-1:0] pair_rise [PAIRS];
    logic [BEAT_W-1:0] pair_fall [PAIRS];

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign pair_rise[p] = data[(2*p)*BEAT_W   +: BEAT_W];
        assign pair_fall[p] = data[(2*p+1)*BEAT_W +: BEAT_W];
    end

    assign rise = pair_rise[ph];
    assign fall = pair_fall[ph];

endmodule

// File: rtl/ddr_burst_pipe.sv
module ddr_burst_pipe
    import ddr_burst_pkg::*;
#(
    parameter int BEAT_W = 8,
    parameter int LAT_W  = 3,
    parameter int CL_MIN = 3,
    parameter int CL_MAX = 6,
    parameter int AL_MAX = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_vld,
    input  logic                cmd_wr,
    input  logic                cmd_bl8,
    input  logic [8*BEAT_W-1:0] cmd_data,
    input  logic [LAT_W-1:0]    cas_lat,
    input  logic [LAT_W-1:0]    add_lat,
    output logic                cmd_rdy,
    output logic                rd_vld,
    output logic [BEAT_W-1:0]   rd_rise,
    output logic [BEAT_W-1:0]   rd_fall,
    output logic                wr_req,
    output logic                strb_ctr
);

    localparam int DATA_W = 8 * BEAT_W;
    localparam int WAIT_W = $clog2(CL_MAX + AL_MAX + 8);
    localparam int SLOTS  = 2;

    typedef struct packed {
        burst_kind_t       kind;
        logic              bl8;
        logic [DATA_W-1:0] data;
        logic [WAIT_W-1:0] wait_c;
    } slot_t;

    typedef struct packed {
        logic [1:0]           cnt;
        slot_t [SLOTS-1:0]    slot;
        logic [1:0]           ph;
        logic                 rd_vld;
        logic [BEAT_W-1:0]    rd_rise;
        logic [BEAT_W-1:0]    rd_fall;
        logic                 wr_req;
        logic                 strb_ctr;
    } state_t;

    state_t st_d, st_q;

    logic              idle, take, pop;
    logic [WAIT_W-1:0] rd_lat, wr_lat, sel_lat;
    logic [WAIT_W:0]   free_off, start_off;
    logic [1:0]        last_ph;
    logic [BEAT_W-1:0] ser_rise, ser_fall;
    slot_t             new_slot;

    assign idle    = (st_q.cnt == 2'd0);
    assign cmd_rdy = (st_q.cnt != 2'd2);
    assign take    = cmd_vld && cmd_rdy;

    ddr_burst_lat #(
        .LAT_W (LAT_W),
        .CL_MIN(CL_MIN),
        .CL_MAX(CL_MAX),
        .AL_MAX(AL_MAX),
        .WAIT_W(WAIT_W)
    ) u_lat (
        .clk    (clk),
        .rst_n  (rst_n),
        .idle   (idle),
        .cas_lat(cas_lat),
        .add_lat(add_lat),
        .rd_lat (rd_lat),
        .wr_lat (wr_lat)
    );

    ddr_burst_ser #(
        .BEAT_W(BEAT_W)
    ) u_ser (
        .data(st_q.slot[0].data),
        .ph  (st_q.ph),
        .rise(ser_rise),
        .fall(ser_fall)
    );

    // Scheduling of an incoming command relative to the head burst
    always_comb begin
        sel_lat = cmd_wr ? wr_lat : rd_lat;
        if (idle)
            free_off = '0;
        else
            free_off = {1'b0, st_q.slot[0].wait_c}
                     + (st_q.slot[0].bl8 ? (WAIT_W+1)'(4) : (WAIT_W+1)'(2))
                     - (WAIT_W+1)'(st_q.ph);
        start_off = (free_off > {1'b0, sel_lat}) ? free_off : {1'b0, sel_lat};

        new_slot.kind   = cmd_wr ? BURST_WR : BURST_RD;
        new_slot.bl8    = cmd_bl8;
        new_slot.data   = cmd_data;
        new_slot.wait_c = WAIT_W'(start_off - (WAIT_W+1)'(1));
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_vld   = 1'b0;
        st_d.rd_rise  = '0;
        st_d.rd_fall  = '0;
        st_d.wr_req   = 1'b0;
        st_d.strb_ctr = 1'b0;
        pop           = 1'b0;
        last_ph       = st_q.slot[0].bl8 ? 2'd3 : 2'd1;

        if (st_q.cnt != 2'd0) begin
            if (st_q.slot[0].wait_c == '0) begin
                if (st_q.slot[0].kind == BURST_WR) begin
                    st_d.wr_req   = 1'b1;
                    st_d.strb_ctr = 1'b1;
                end else begin
                    st_d.rd_vld  = 1'b1;
                    st_d.rd_rise = ser_rise;
                    st_d.rd_fall = ser_fall;
                end
                if (st_q.ph == last_ph) begin
                    pop     = 1'b1;
                    st_d.ph = 2'd0;
                end else begin
                    st_d.ph = st_q.ph + 2'd1;
                end
            end else begin
                st_d.slot[0].wait_c = st_q.slot[0].wait_c - WAIT_W'(1);
            end
        end

        if (st_q.cnt == 2'd2 && st_q.slot[1].wait_c != '0)
            st_d.slot[1].wait_c = st_q.slot[1].wait_c - WAIT_W'(1);

        if (pop) begin
            st_d.slot[0] = st_d.slot[1];
            st_d.cnt     = st_q.cnt - 2'd1;
        end

        if (take) begin
            if (st_d.cnt == 2'd0)
                st_d.slot[0] = new_slot;
            else
                st_d.slot[1] = new_slot;
            st_d.cnt = st_d.cnt + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_vld   = st_q.rd_vld;
    assign rd_rise  = st_q.rd_rise;
    assign rd_fall  = st_q.rd_fall;
    assign wr_req   = st_q.wr_req;
    assign strb_ctr = st_q.strb_ctr;

endmodule

// File: rtl/ddr_burst_pipe_chk.sv
module ddr_burst_pipe_chk #(
    parameter int BEAT_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_vld,
    input logic              cmd_rdy,
    input logic              rd_vld,
    input logic [BEAT_W-1:0] rd_rise,
    input logic [BEAT_W-1:0] rd_fall,
    input logic              wr_req,
    input logic              strb_ctr
);

    // R6
    no_rd_wr_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_vld && wr_req));

    // R6
    center_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strb_ctr |-> wr_req);

    // R11
    quiet_read_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |-> (rd_rise == '0 && rd_fall == '0));

    // R9
    rdy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_rdy) |-> $past(cmd_vld));

    // R4
    rd_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_vld) |=> rd_vld);

    // R4
    wr_min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |=> wr_req);

endmodule

bind ddr_burst_pipe ddr_burst_pipe_chk #(.BEAT_W(BEAT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_vld (cmd_vld),
    .cmd_rdy (cmd_rdy),
    .rd_vld  (rd_vld),
    .rd_rise (rd_rise),
    .rd_fall (rd_fall),
    .wr_req  (wr_req),
    .strb_ctr(strb_ctr)
);

// File: tb/ddr_burst_pipe_test.sv
module ddr_burst_pipe_test;

    localparam int BW = 8;
    localparam int HN = 1024;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cmd_vld, cmd_wr, cmd_bl8;
    logic [63:0]   cmd_data;
    logic [2:0]    cas_lat, add_lat;
    logic          cmd_rdy, rd_vld, wr_req, strb_ctr;
    logic [BW-1:0] rd_rise, rd_fall;

    always #5 clk = ~clk;

    ddr_burst_pipe uut (
        .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_wr(cmd_wr),
        .cmd_bl8(cmd_bl8), .cmd_data(cmd_data), .cas_lat(cas_lat),
        .add_lat(add_lat), .cmd_rdy(cmd_rdy), .rd_vld(rd_vld),
        .rd_rise(rd_rise), .rd_fall(rd_fall), .wr_req(wr_req),
        .strb_ctr(strb_ctr)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic          h_rdy [HN];
    logic          h_rd  [HN];
    logic          h_wr  [HN];
    logic          h_ctr [HN];
    logic [BW-1:0] h_ri  [HN];
    logic [BW-1:0] h_fa  [HN];

    typedef struct packed {
        logic        wr;
        logic        bl8;
        logic [2:0]  cl;
        logic [2:0]  al;
        logic [4:0]  lat;
        logic [63:0] data;
    } vec_t;

    // lat = expected cycles from accepting edge to first beat clock
    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 3'd3, 3'd0, 5'd3,  64'h0807060504030201},
        '{1'b0, 1'b1, 3'd4, 3'd1, 5'd5,  64'hF1E2D3C4B5A69788},
        '{1'b1, 1'b0, 3'd3, 3'd0, 5'd2,  64'h0},
        '{1'b1, 1'b1, 3'd6, 3'd2, 5'd7,  64'h0},
        '{1'b0, 1'b1, 3'd6, 3'd5, 5'd11, 64'h1122334455667788},
        '{1'b0, 1'b0, 3'd2, 3'd0, 5'd3,  64'h00000000CAFEBEEF},
        '{1'b0, 1'b0, 3'd7, 3'd7, 5'd11, 64'h000000005A5AA5A5},
        '{1'b1, 1'b0, 3'd5, 3'd3, 5'd7,  64'h0}
    };

    task automatic step();
        @(negedge clk);
        h_rdy[cyc] = cmd_rdy;
        h_rd[cyc]  = rd_vld;
        h_wr[cyc]  = wr_req;
        h_ctr[cyc] = strb_ctr;
        h_ri[cyc]  = rd_rise;
        h_fa[cyc]  = rd_fall;
        cyc++;
    endtask

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input bit wr, input bit bl8, input logic [63:0] d);
        cmd_vld  = 1'b1;
        cmd_wr   = wr;
        cmd_bl8  = bl8;
        cmd_data = d;
        step();
        cmd_vld  = 1'b0;
        cmd_data = '0;
    endtask

    // Burst accepted at history index c0, first beat clock at c0+lat
    task automatic check_burst(input int c0, input int lat, input bit wr,
                               input bit bl8, input logic [63:0] d,
                               input string tag, input bit pre, input bit post);
        int len = bl8 ? 4 : 2;
        int c;
        if (pre) begin
            c = c0 + lat - 1;
            chk(!h_rd[c] && !h_wr[c], {tag, " early start"},
                {h_rd[c], h_wr[c]}, 0);
            chk(h_ri[c] == 0 && h_fa[c] == 0, "R11 quiet data",
                {h_ri[c], h_fa[c]}, 0);
        end
        for (int p = 0; p < len; p++) begin
            c = c0 + lat + p;
            if (wr) begin
                chk(h_wr[c] && h_ctr[c] && !h_rd[c], {tag, " R4 R6 write beat"},
                    {h_wr[c], h_ctr[c], h_rd[c]}, 3'b110);
            end else begin
                chk(h_rd[c] && !h_ctr[c] && !h_wr[c], {tag, " R4 R6 read beat"},
                    {h_rd[c], h_ctr[c], h_wr[c]}, 3'b100);
                chk(h_ri[c] == d[(2*p)*BW +: BW] && h_fa[c] == d[(2*p+1)*BW +: BW],
                    "R5 beat order", {h_ri[c], h_fa[c]},
                    {d[(2*p)*BW +: BW], d[(2*p+1)*BW +: BW]});
            end
        end
        if (post) begin
            c = c0 + lat + len;
            chk(!h_rd[c] && !h_wr[c], {tag, " R4 late end"}, {h_rd[c], h_wr[c]}, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int c0;
        rst_n = 1'b0;
        cmd_vld = 1'b0; cmd_wr = 1'b0; cmd_bl8 = 1'b0; cmd_data = '0;
        cas_lat = 3'd3; add_lat = 3'd0;
        repeat (3) step();
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(h_rdy[cyc-1] == 1'b1, "R1 cmd_rdy", h_rdy[cyc-1], 1);
        chk(h_rd[cyc-1] == 1'b0, "R1 rd_vld", h_rd[cyc-1], 0);
        chk(h_wr[cyc-1] == 1'b0, "R1 wr_req", h_wr[cyc-1], 0);
        chk(h_ctr[cyc-1] == 1'b0, "R1 strb_ctr", h_ctr[cyc-1], 0);

        // R2 R3 single bursts; vectors 5 and 6 cover R7 clamping
        for (int i = 0; i < 8; i++) begin
            string tag;
            cas_lat = VECS[i].cl;
            add_lat = VECS[i].al;
            step();
            c0 = cyc;
            issue(VECS[i].wr, VECS[i].bl8, VECS[i].data);
            repeat (20) step();
            tag = (i == 5 || i == 6) ? "R7" : (VECS[i].wr ? "R3" : "R2");
            check_burst(c0, int'(VECS[i].lat), VECS[i].wr, VECS[i].bl8,
                        VECS[i].data, tag, 1'b1, 1'b1);
        end

        // R8 R9: read BL8, write queued behind it, third command refused
        cas_lat = 3'd3; add_lat = 3'd0;
        step();
        c0 = cyc;
        issue(1'b0, 1'b1, 64'h8877665544332211);
        issue(1'b1, 1'b0, 64'h0);
        issue(1'b0, 1'b0, 64'h00000000DEADD00D);
        repeat (22) step();
        check_burst(c0, 3, 1'b0, 1'b1, 64'h8877665544332211, "R8 head", 1'b1, 1'b0);
        check_burst(c0 + 1, 6, 1'b1, 1'b0, 64'h0, "R8 queued", 1'b0, 1'b1);
        chk(h_rdy[c0] == 1'b1, "R9 rdy one held", h_rdy[c0], 1);
        chk(h_rdy[c0 + 1] == 1'b0, "R9 rdy two held", h_rdy[c0 + 1], 0);
        chk(h_rdy[c0 + 5] == 1'b0, "R9 rdy before pop", h_rdy[c0 + 5], 0);
        chk(h_rdy[c0 + 6] == 1'b1, "R9 rdy after pop", h_rdy[c0 + 6], 1);
        begin
            int stray = 0;
            for (int c = c0 + 9; c < c0 + 22; c++)
                if (h_rd[c] || h_wr[c]) stray++;
            chk(stray == 0, "R9 refused command", stray, 0);
        end

        // R8 two reads packed back to back
        c0 = cyc;
        issue(1'b0, 1'b0, 64'h00000000A4A3A2A1);
        issue(1'b0, 1'b0, 64'h00000000B4B3B2B1);
        repeat (20) step();
        check_burst(c0, 3, 1'b0, 1'b0, 64'h00000000A4A3A2A1, "R8 first", 1'b1, 1'b0);
        check_burst(c0 + 1, 4, 1'b0, 1'b0, 64'h00000000B4B3B2B1, "R8 second", 1'b0, 1'b1);

        // R10 latency change while busy is held off until idle
        c0 = cyc;
        issue(1'b0, 1'b1, 64'h0F0E0D0C0B0A0908);
        cas_lat = 3'd6; add_lat = 3'd2;
        issue(1'b0, 1'b0, 64'h0000000013121110);
        repeat (20) step();
        check_burst(c0, 3, 1'b0, 1'b1, 64'h0F0E0D0C0B0A0908, "R10 head", 1'b1, 1'b0);
        check_burst(c0 + 1, 6, 1'b0, 1'b0, 64'h0000000013121110, "R10 held", 1'b0, 1'b1);
        c0 = cyc;
        issue(1'b0, 1'b0, 64'h0000000023222120);
        repeat (20) step();
        check_burst(c0, 8, 1'b0, 1'b0, 64'h0000000023222120, "R10 idle update", 1'b1, 1'b1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule